// File: doc/BRIEF.md
# Asynchronous NOR Flash Read Sequencer

This block runs read accesses to an asynchronous parallel NOR flash. A host issues a request with a start address, a word count and byte enables. The block places the address on the flash pins, lowers chip select, pulses address-valid and holds output enable. It captures the flash data bus on programmed edges of its own clock and hands each captured word back with a one-cycle valid strobe. After the last word, it raises chip select and pulses a done flag.

All timing comes from configuration inputs held stable while an access is in progress. These inputs set the first-word access time, the successive-word page time, the chip-select pulse length, the address-valid length, the output-enable length and the address lead. A single granularity bit doubles every count when it is set. A request for more than one word is a page read. The word-select address bits step after each captured word, and chip select and output enable stay low across the whole page.

Top module: `nor_rd_seq`

## Requirements
- R1: With H = max(cfg_acc_time,1) x (cfg_gran+1), the first word is captured on the clock edge H cycles after the cycle in which flash_cs_n first goes low. It appears on rd_data with rd_valid high for exactly one cycle, H cycles after the chip-select fall cycle.
- R2: A request with req_len = L returns L+1 words. L = 0 is a single read and L > 0 is a page read. Word k+1 is captured P cycles after word k, where P = max(cfg_page_time,1) x (cfg_gran+1).
- R3: With cfg_gran = 1, every programmed count is doubled: access, page, chip-select, address-valid, output-enable and address lead.
- R4: An access time or page time of zero behaves as one, and an address-valid length of zero behaves as one.
- R5: flash_addr and flash_be_n are driven J = cfg_addr_lead x (cfg_gran+1) cycles before flash_cs_n falls. flash_addr equals req_addr when chip select falls.
- R6: With Tlast = H + L x P, flash_cs_n stays low for max(A, Tlast+1) cycles, where A = cfg_cs_len x (cfg_gran+1).
- R7: flash_adv_n is low from the chip-select fall for min(max(cfg_adv_len,1) x (cfg_gran+1), chip-select length) cycles.
- R8: For a single read, flash_oe_n is low from the chip-select fall for min(max(C, Tlast), chip-select length) cycles, where C = cfg_oe_len x (cfg_gran+1). For a page read it is low for the whole chip-select length.
- R9: flash_be_n equals the inverse of req_be (active low, bit i for byte lane i). It holds that value unchanged from the first address-lead cycle to the last chip-select cycle and is all ones otherwise.
- R10: In a page read, the low LEN_W address bits advance by one, wrapping within the page, after every captured word except the last. The upper bits do not change.
- R11: rd_done is high for one cycle, in the first cycle flash_cs_n is high after an access. req_ready is low in that cycle, so chip select stays high for at least one cycle before a new request is accepted.
- R12: During reset, flash_cs_n, flash_oe_n and flash_adv_n are high, flash_be_n is all ones, rd_valid and rd_done are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_acc_time | input | TIM_W | First-word access time |
| cfg_page_time | input | TIM_W | Successive page-word time |
| cfg_gran | input | 1 | Doubles all counts when set |
| cfg_cs_len | input | TIM_W | Minimum chip-select low length |
| cfg_adv_len | input | TIM_W | Address-valid low length |
| cfg_oe_len | input | TIM_W | Output-enable length, single reads |
| cfg_addr_lead | input | TIM_W | Address lead before chip select |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Word count minus one |
| req_be | input | BE_W | Byte lanes to enable, active high |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_be_n | output | BE_W | Flash byte enables, active low |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_adv_n | output | 1 | Flash address-valid, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_dq | input | DATA_W | Flash data bus |
| rd_data | output | DATA_W | Captured word |
| rd_valid | output | 1 | rd_data valid strobe |
| rd_done | output | 1 | Access finished |

## Verification
The hardest thing to observe from the ports is the exact capture edge, because the flash would normally hold one value across the whole window. The bench flash model therefore drives a word that combines the number of cycles since chip select fell with the low address byte. Each captured word then shows the edge it was sampled on and the page address in use at that edge. Page reads that start near the end of a page, long chip-select settings that outlast the last word, and zero or doubled counts drive the stop and clamp conditions into their less common branches.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_ACT   = 2'd2,
    ST_RECOV = 2'd3
  } nrs_state_e;

  // timing field slots
  localparam int NUM_TF  = 6;
  localparam int TF_ACC  = 0;
  localparam int TF_PAGE = 1;
  localparam int TF_CS   = 2;
  localparam int TF_ADV  = 3;
  localparam int TF_OE   = 4;
  localparam int TF_LEAD = 5;

  // fields where zero counts as one: access, page, address-valid
  localparam logic [NUM_TF-1:0] CLAMP_MASK = 6'b001011;

endpackage

// File: rtl/nrs_scale.sv
module nrs_scale #(
  parameter int  IN_W  = 5,
  parameter bit  CLAMP = 1'b0
) (
  input  logic [IN_W-1:0] val,
  input  logic            gran,
  output logic [IN_W:0]   scaled
);
  logic [IN_W-1:0] base;

  always_comb begin
    if (CLAMP && (val == '0)) base = {{(IN_W-1){1'b0}}, 1'b1};
    else                      base = val;
    if (gran) scaled = {base, 1'b0};
    else      scaled = {1'b0, base};
  end
endmodule

// File: rtl/nrs_addr.sv
module nrs_addr #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 2,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [BE_W-1:0]   be_in,
  output logic [ADDR_W-1:0] addr,
  output logic [BE_W-1:0]   be
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BE_W-1:0]   be_q, be_d;
  logic [LEN_W-1:0]  word_inc;

  always_comb begin
    word_inc = addr_q[LEN_W-1:0] + 1'b1;
    addr_d   = addr_q;
    be_d     = be_q;
    if (load) begin
      addr_d = base;
      be_d   = be_in;
    end else if (step) begin
      addr_d = {addr_q[ADDR_W-1:LEN_W], word_inc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
    end else begin
      addr_q <= addr_d;
      be_q   <= be_d;
    end
  end

  assign addr = addr_q;
  assign be   = be_q;
endmodule

// File: rtl/nrs_capture.sv
module nrs_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q;

  always_comb begin
    data_d = data_q;
    if (fire) data_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= fire;
    end
  end

  assign dout   = data_q;
  assign dvalid = vld_q;
endmodule

// File: rtl/nrs_ctrl.sv
module nrs_ctrl
  import nor_rd_pkg::*;
#(
  parameter int SC_W  = 6,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic [SC_W-1:0]  h_eff,
  input  logic [SC_W-1:0]  p_eff,
  input  logic [SC_W-1:0]  a_eff,
  input  logic [SC_W-1:0]  b_eff,
  input  logic [SC_W-1:0]  c_eff,
  input  logic [SC_W-1:0]  j_eff,
  output logic             ready,
  output logic             load,
  output logic             fire,
  output logic             step,
  output logic             bus_act,
  output logic             cs_n,
  output logic             adv_n,
  output logic             oe_n,
  output logic             done
);
  localparam int               T_W   = SC_W + LEN_W + 1;
  localparam logic [T_W-1:0]   T_MAX = '1;

  nrs_state_e       st_q, st_d;
  logic [T_W-1:0]   t_q, t_d;
  logic [SC_W-1:0]  smp_q, smp_d;
  logic [SC_W-1:0]  lead_q, lead_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             fin_q, fin_d;
  logic             pg_q, pg_d;

  logic [T_W:0]     t_plus;
  logic [T_W:0]     a_ext;
  logic [T_W-1:0]   b_ext, c_ext;

  always_comb begin
    t_plus = {1'b0, t_q} + 1'b1;
    a_ext  = {{(T_W + 1 - SC_W){1'b0}}, a_eff};
    b_ext  = {{(T_W - SC_W){1'b0}}, b_eff};
    c_ext  = {{(T_W - SC_W){1'b0}}, c_eff};
  end

  // next-state
  always_comb begin
    st_d   = st_q;
    t_d    = t_q;
    smp_d  = smp_q;
    lead_d = lead_q;
    rem_d  = rem_q;
    fin_d  = fin_q;
    pg_d   = pg_q;
    load   = 1'b0;
    fire   = 1'b0;
    step   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          load  = 1'b1;
          pg_d  = (req_len != '0);
          rem_d = req_len;
          t_d   = '0;
          smp_d = h_eff - 1'b1;
          fin_d = 1'b0;
          if (j_eff == '0) begin
            st_d = ST_ACT;
          end else begin
            lead_d = j_eff - 1'b1;
            st_d   = ST_LEAD;
          end
        end
      end
      ST_LEAD: begin
        if (lead_q == '0) st_d = ST_ACT;
        else              lead_d = lead_q - 1'b1;
      end
      ST_ACT: begin
        if (t_q != T_MAX) t_d = t_q + 1'b1;
        if (!fin_q) begin
          if (smp_q == '0) begin
            fire = 1'b1;
            if (rem_q == '0) begin
              fin_d = 1'b1;
            end else begin
              step  = 1'b1;
              rem_d = rem_q - 1'b1;
              smp_d = p_eff - 1'b1;
            end
          end else begin
            smp_d = smp_q - 1'b1;
          end
        end
        if (fin_q && (t_plus >= a_ext)) st_d = ST_RECOV;
      end
      ST_RECOV: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      t_q    <= '0;
      smp_q  <= '0;
      lead_q <= '0;
      rem_q  <= '0;
      fin_q  <= 1'b0;
      pg_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      t_q    <= t_d;
      smp_q  <= smp_d;
      lead_q <= lead_d;
      rem_q  <= rem_d;
      fin_q  <= fin_d;
      pg_q   <= pg_d;
    end
  end

  // strobe decode from registered state
  always_comb begin
    ready   = (st_q == ST_IDLE);
    done    = (st_q == ST_RECOV);
    bus_act = (st_q == ST_LEAD) || (st_q == ST_ACT);
    cs_n    = (st_q != ST_ACT);
    adv_n   = !((st_q == ST_ACT) && (t_q < b_ext));
    oe_n    = !((st_q == ST_ACT) && (pg_q || !fin_q || (t_q < c_ext)));
  end
endmodule

// File: rtl/nor_rd_seq.sv
module nor_rd_seq
  import nor_rd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2,
  parameter int TIM_W  = 5,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIM_W-1:0]  cfg_acc_time,
  input  logic [TIM_W-1:0]  cfg_page_time,
  input  logic              cfg_gran,
  input  logic [TIM_W-1:0]  cfg_cs_len,
  input  logic [TIM_W-1:0]  cfg_adv_len,
  input  logic [TIM_W-1:0]  cfg_oe_len,
  input  logic [TIM_W-1:0]  cfg_addr_lead,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BE_W-1:0]   req_be,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [BE_W-1:0]   flash_be_n,
  output logic              flash_cs_n,
  output logic              flash_adv_n,
  output logic              flash_oe_n,
  input  logic [DATA_W-1:0] flash_dq,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_done
);
  localparam int SC_W = TIM_W + 1;

  logic [TIM_W-1:0] tf_raw [NUM_TF];
  logic [SC_W-1:0]  tf_eff [NUM_TF];

  always_comb begin
    tf_raw[TF_ACC]  = cfg_acc_time;
    tf_raw[TF_PAGE] = cfg_page_time;
    tf_raw[TF_CS]   = cfg_cs_len;
    tf_raw[TF_ADV]  = cfg_adv_len;
    tf_raw[TF_OE]   = cfg_oe_len;
    tf_raw[TF_LEAD] = cfg_addr_lead;
  end

  for (genvar gi = 0; gi < NUM_TF; gi++) begin : g_scale
    nrs_scale #(
      .IN_W  (TIM_W),
      .CLAMP (CLAMP_MASK[gi])
    ) u_scale (
      .val    (tf_raw[gi]),
      .gran   (cfg_gran),
      .scaled (tf_eff[gi])
    );
  end

  logic             load, fire, step, bus_act;
  logic [BE_W-1:0]  be_q;

  nrs_ctrl #(
    .SC_W  (SC_W),
    .LEN_W (LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_len   (req_len),
    .h_eff     (tf_eff[TF_ACC]),
    .p_eff     (tf_eff[TF_PAGE]),
    .a_eff     (tf_eff[TF_CS]),
    .b_eff     (tf_eff[TF_ADV]),
    .c_eff     (tf_eff[TF_OE]),
    .j_eff     (tf_eff[TF_LEAD]),
    .ready     (req_ready),
    .load      (load),
    .fire      (fire),
    .step      (step),
    .bus_act   (bus_act),
    .cs_n      (flash_cs_n),
    .adv_n     (flash_adv_n),
    .oe_n      (flash_oe_n),
    .done      (rd_done)
  );

  nrs_addr #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .BE_W   (BE_W)
  ) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .base  (req_addr),
    .be_in (req_be),
    .addr  (flash_addr),
    .be    (be_q)
  );

  assign flash_be_n = bus_act ? ~be_q : {BE_W{1'b1}};

  nrs_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .din    (flash_dq),
    .dout   (rd_data),
    .dvalid (rd_valid)
  );
endmodule

// File: rtl/nrs_chk.sv
module nrs_chk #(
  parameter int ADDR_W = 20,
  parameter int BE_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [BE_W-1:0]   flash_be_n,
  input logic              flash_cs_n,
  input logic              flash_adv_n,
  input logic              flash_oe_n,
  input logic              rd_valid,
  input logic              rd_done
);
  // R1: captured words are presented only right after a chip-select cycle
  p_valid_in_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(flash_cs_n));

  // R7: address-valid only inside chip select
  p_adv_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_adv_n |-> !flash_cs_n);

  // R8: output enable only inside chip select
  p_oe_in_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n |-> !flash_cs_n);

  // R9: byte enables constant across chip select
  p_be_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_cs_n && !$past(flash_cs_n)) |-> $stable(flash_be_n));

  // R10: address moves only together with a captured word
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_cs_n && !$past(flash_cs_n) && !rd_valid) |-> $stable(flash_addr));

  // R11: done follows the chip-select rise, and not while idle
  p_done_after_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (flash_cs_n && !$past(flash_cs_n) && !req_ready));

  // R11: ready only while the flash bus is quiet
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (flash_cs_n && flash_oe_n && (flash_be_n == {BE_W{1'b1}})));
endmodule

bind nor_rd_seq nrs_chk #(
  .ADDR_W (ADDR_W),
  .BE_W   (BE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .flash_addr  (flash_addr),
  .flash_be_n  (flash_be_n),
  .flash_cs_n  (flash_cs_n),
  .flash_adv_n (flash_adv_n),
  .flash_oe_n  (flash_oe_n),
  .rd_valid    (rd_valid),
  .rd_done     (rd_done)
);

// File: tb/sim_nor_rd_seq.sv
module sim_nor_rd_seq;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BW = 2;
  localparam int TW = 5;
  localparam int LW = 2;
  localparam logic [AW-1:0] WMASK = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] cfg_acc_time = '0, cfg_page_time = '0, cfg_cs_len = '0;
  logic [TW-1:0] cfg_adv_len = '0, cfg_oe_len = '0, cfg_addr_lead = '0;
  logic cfg_gran = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [BW-1:0] req_be = '0;
  logic [AW-1:0] flash_addr;
  logic [BW-1:0] flash_be_n;
  logic flash_cs_n, flash_adv_n, flash_oe_n;
  logic [DW-1:0] flash_dq = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, rd_done;

  always #4 clk = ~clk;

  nor_rd_seq #(.ADDR_W(AW), .DATA_W(DW), .BE_W(BW), .TIM_W(TW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_acc_time(cfg_acc_time), .cfg_page_time(cfg_page_time), .cfg_gran(cfg_gran),
    .cfg_cs_len(cfg_cs_len), .cfg_adv_len(cfg_adv_len), .cfg_oe_len(cfg_oe_len),
    .cfg_addr_lead(cfg_addr_lead),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_be(req_be),
    .flash_addr(flash_addr), .flash_be_n(flash_be_n), .flash_cs_n(flash_cs_n),
    .flash_adv_n(flash_adv_n), .flash_oe_n(flash_oe_n), .flash_dq(flash_dq),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  typedef struct {
    int h, p, n, a, b, c, j;
    bit page;
    logic [AW-1:0] base;
    logic [BW-1:0] be;
  } tx_t;

  tx_t   txq[$];
  string tagq[$];

  function automatic int sc(input int v, input int g, input bit clamp);
    int b;
    b = (clamp && v == 0) ? 1 : v;
    return b * (g + 1);
  endfunction

  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] base, input int k);
    logic [AW-1:0] s;
    s = base + AW'(k);
    return (base & ~WMASK) | (s & WMASK);
  endfunction

  // driver: wait idle, program timing, issue request, push expectation
  task automatic do_read(input int acc, input int pacc, input int g, input int a,
                         input int b, input int c, input int j,
                         input logic [AW-1:0] base, input int len,
                         input logic [BW-1:0] be, input string tag);
    tx_t t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_acc_time  = TW'(acc);
    cfg_page_time = TW'(pacc);
    cfg_gran      = g[0];
    cfg_cs_len    = TW'(a);
    cfg_adv_len   = TW'(b);
    cfg_oe_len    = TW'(c);
    cfg_addr_lead = TW'(j);
    req_addr      = base;
    req_len       = LW'(len);
    req_be        = be;
    req_valid     = 1'b1;
    t.h = sc(acc, g, 1); t.p = sc(pacc, g, 1); t.n = len + 1;
    t.a = sc(a, g, 0);   t.b = sc(b, g, 1);    t.c = sc(c, g, 0);
    t.j = sc(j, g, 0);   t.page = (len != 0);  t.base = base; t.be = be;
    txq.push_back(t);
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor and flash model
  bit   in_cs = 0;
  int   cs_t = 0, adv_cnt = 0, oe_cnt = 0, lead_cnt = 0, wk = 0, cs_len_meas = 0;
  tx_t  cur;
  string ctag;

  always @(negedge clk) begin
    if (rst_n) begin
      bit ended;
      ended = 0;
      if (!flash_cs_n) begin
        if (!in_cs) begin
          in_cs = 1; cs_t = 0; adv_cnt = 0; oe_cnt = 0; wk = 0;
          if (txq.size() == 0) begin
            chk("R5 unexpected access", 1, 0);
          end else begin
            cur = txq[0]; ctag = tagq[0];
            chk({"R5 lead cycles ", ctag}, lead_cnt, cur.j);
            chk({"R5 address at cs fall ", ctag}, int'(flash_addr), int'(cur.base));
          end
        end else begin
          cs_t++;
        end
        if (!flash_adv_n) adv_cnt++;
        if (!flash_oe_n) oe_cnt++;
        if (flash_be_n != ~cur.be)
          chk({"R9 byte enables ", ctag}, int'(flash_be_n), int'(~cur.be));
        lead_cnt = 0;
      end else begin
        if (in_cs) begin
          in_cs = 0; ended = 1; cs_len_meas = cs_t + 1;
        end
        if (flash_be_n != '1) lead_cnt++;
        else lead_cnt = 0;
      end

      if (rd_valid) begin
        int exp_cyc;
        logic [DW-1:0] exp_d;
        logic [AW-1:0] wa;
        exp_cyc = cur.h + wk * cur.p;
        wa = word_addr(cur.base, wk);
        exp_d = {8'(exp_cyc - 1), wa[7:0]};
        chk({"R1 R2 valid cycle ", ctag}, cs_t, exp_cyc);
        chk({"R1 R2 data edge ", ctag}, int'(rd_data), int'(exp_d));
        if (cur.page)
          chk({"R10 word address ", ctag}, int'(flash_addr),
              int'(word_addr(cur.base, (wk + 1 < cur.n) ? wk + 1 : cur.n - 1)));
        wk++;
      end

      if (rd_done) begin
        int tl, csl, advl, oel;
        tl   = cur.h + (cur.n - 1) * cur.p;
        csl  = (cur.a > tl + 1) ? cur.a : tl + 1;
        advl = (cur.b < csl) ? cur.b : csl;
        if (cur.page) oel = csl;
        else begin
          oel = (cur.c > tl) ? cur.c : tl;
          if (oel > csl) oel = csl;
        end
        chk({"R11 done right after cs rise ", ctag}, int'(ended), 1);
        chk({"R11 ready low at done ", ctag}, int'(req_ready), 0);
        chk({"R2 word count ", ctag}, wk, cur.n);
        chk({"R6 cs length ", ctag}, cs_len_meas, csl);
        chk({"R7 adv length ", ctag}, adv_cnt, advl);
        chk({"R8 oe length ", ctag}, oe_cnt, oel);
        chk({"R9 be released ", ctag}, int'(flash_be_n), 3);
        void'(txq.pop_front());
        void'(tagq.pop_front());
      end

      // flash model: word reveals cycle index and low address byte
      if (!flash_cs_n && !flash_oe_n) flash_dq = {8'(cs_t), flash_addr[7:0]};
      else                            flash_dq = 16'hDEAD;
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 cs_n in reset", int'(flash_cs_n), 1);
    chk("R12 oe_n in reset", int'(flash_oe_n), 1);
    chk("R12 adv_n in reset", int'(flash_adv_n), 1);
    chk("R12 be_n in reset", int'(flash_be_n), 3);
    chk("R12 valid/done in reset", int'({rd_valid, rd_done}), 0);
    chk("R12 ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;

    //       acc pac g  a  b  c  j  base       len be
    do_read(3, 0, 0, 2, 1, 1, 0, 20'h01234, 0, 2'b01, "R1 single short");
    do_read(4, 0, 0, 9, 3, 7, 2, 20'h0ABCD, 0, 2'b11, "R6 R5 R8 long cs");
    do_read(3, 0, 1, 3, 2, 2, 1, 20'h05550, 0, 2'b10, "R3 gran single");
    do_read(0, 0, 0, 0, 0, 0, 0, 20'h00007, 0, 2'b11, "R4 zero counts");
    do_read(5, 2, 0, 0, 1, 0, 0, 20'h00A46, 3, 2'b11, "R2 R10 page wrap");
    do_read(2, 0, 1, 1, 1, 1, 2, 20'hFFFF1, 2, 2'b01, "R3 R4 page gran");
    do_read(1, 3, 0, 20, 4, 0, 3, 20'h12340, 1, 2'b10, "R6 page long cs");
    // back-to-back singles
    do_read(2, 0, 0, 0, 1, 0, 0, 20'h00011, 0, 2'b11, "R11 b2b first");
    do_read(2, 0, 0, 0, 1, 0, 0, 20'h00022, 0, 2'b11, "R11 b2b second");

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11 all accesses completed", txq.size(), 0);
    finish_run();
  end
endmodule